// File: doc/BRIEF.md
# Mode-Selected Multi-Output Clock Divider Bank

This block takes one fast master clock and produces a family of related clock outputs through integer dividers. The outputs are processor-core, memory, 66 MHz hub, 33 MHz bus, 33 MHz interrupt-controller, 48 MHz peripheral and reference clocks. A 3-bit select input picks one of three operating modes. In the first mode every output is disabled. In the second, a test mode, the master input carries an external test clock and fixed ratios are applied to it. In the third, the normal mode, the master comes from a synthesizer and parameterized ratios set the nominal rates. Combinations outside these three run at the normal ratios and raise a flag.

Each output group has a single divider that feeds all copies of that group. Odd ratios get a duty cycle of exactly one half by combining a rising-edge state bit with a falling-edge copy of it. Each time the select value is taken in, which happens after reset and on every later change, all dividers restart from a common point. The processor, memory, peripheral and reference group starts first. The hub, bus and interrupt-controller group starts a programmable whole number of master cycles later, so the processor clocks lead the slower groups by a fixed offset while hub and bus edges stay coincident. The normal defaults assume a 600 MHz master: /6 gives 100, /9 gives 66.7, /18 gives 33.3, /13 gives about 46.2 and /42 gives about 14.29 MHz. The last two are the nearest integer approximations to 48 MHz and to the 14.318 MHz reference.

Top module: `clkdiv_bank`

## Requirements
- R1: When freq_sel[2]=0 and freq_sel[0]=0 (off mode), clk_oe is 0 and every clock output is held at 0.
- R2: When freq_sel[2]=0 and freq_sel[0]=1 (test mode), the divide ratios applied to the master clock are: core and mem 2, usb 2, hub 3, bus and apic 6, ref 1 (ref follows the master clock level).
- R3: When freq_sel=3'b101 (normal mode), the ratios are the parameters NORM_CORE (6) for core and mem, NORM_USB (13), NORM_REF (42), NORM_HUB (9), and NORM_BUS (18) for bus and apic.
- R4: When freq_sel[2]=1 and freq_sel[1:0]!=2'b01, the outputs run at the normal-mode ratios and sel_bad is 1. In every other mode sel_bad is 0.
- R5: A running output with ratio N is high for exactly N master half-periods out of every 2N, and this holds for odd N as well.
- R6: The select value is taken in at the first rising edge after reset release, and again at any rising edge where it differs from the value last taken. Call that edge E0. The core, mem, usb and ref outputs give their first high phase starting at rising edge E0+2, all together.
- R7: The hub, bus and apic outputs give their first high phase at rising edge E0+2+S, where S is skew_cyc as taken at E0. After that, every rising edge of bus coincides with a rising edge of hub.
- R8: Changes to skew_cyc at edges other than E0 have no effect on the running offset.
- R9: All copies inside the core and mem outputs carry the same waveform, and core equals mem.
- R10: While rst_n is low, clk_oe, sel_bad and all clock outputs are 0.
- R11: From edge E0 until the group's first rising edge, every clock output of that group is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (synthesizer output or external test clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_sel | input | 3 | Mode select |
| skew_cyc | input | SKW_W | Processor-to-slow-group offset in master cycles |
| core_clk | output | N_CORE | Processor clocks |
| mem_clk | output | N_MEM | Memory clocks |
| hub_clk | output | N_HUB | 66 MHz hub clocks |
| bus_clk | output | N_BUS | 33 MHz bus clocks |
| apic_clk | output | N_APIC | 33 MHz interrupt-controller clocks |
| usb_clk | output | 1 | 48 MHz class peripheral clock |
| ref_clk | output | 1 | Reference clock |
| clk_oe | output | 1 | Output enable for all clock pads (0 = high impedance) |
| sel_bad | output | 1 | Illegal select combination in use |

## Verification
The hardest situations to reach from the ports are a mode change landing in the middle of a running period of an odd divider, and a skew change arriving while no restart is in progress. The stimulus switches freq_sel at arbitrary points in the long normal-mode periods and changes skew_cyc both with and without a select change. A behavioural model rebuilds every waveform from the restart edge and compares all outputs in both the high and the low phase of every master cycle. Separate window counts measure the duty of the odd ratios.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int RATIO_W = 8;
    localparam int NGRP    = 5;

    // group indices; each group owns one divider
    localparam int G_CORE = 0;
    localparam int G_USB  = 1;
    localparam int G_REF  = 2;
    localparam int G_HUB  = 3;
    localparam int G_BUS  = 4;

    // groups that start after the programmable offset
    localparam logic [NGRP-1:0] SLOW_MASK = 5'b11000;

    typedef enum logic [1:0] {
        OP_OFF  = 2'd0,
        OP_TEST = 2'd1,
        OP_RUN  = 2'd2
    } op_mode_e;

    typedef logic [NGRP-1:0][RATIO_W-1:0] ratio_vec_t;

    function automatic op_mode_e sel_to_mode(logic [2:0] s);
        if (!s[2]) return s[0] ? OP_TEST : OP_OFF;
        return OP_RUN;
    endfunction

    function automatic logic sel_is_bad(logic [2:0] s);
        return s[2] && (s[1:0] != 2'b01);
    endfunction

endpackage

// File: rtl/clkdiv_mode_dec.sv
module clkdiv_mode_dec
    import clkdiv_pkg::*;
#(
    parameter int NORM_CORE = 6,
    parameter int NORM_USB  = 13,
    parameter int NORM_REF  = 42,
    parameter int NORM_HUB  = 9,
    parameter int NORM_BUS  = 18
) (
    input  logic       valid,
    input  logic [2:0] sel,
    output op_mode_e   mode,
    output logic       bad,
    output ratio_vec_t ratio
);

    localparam int TST_CORE = 2;
    localparam int TST_USB  = 2;
    localparam int TST_REF  = 1;
    localparam int TST_HUB  = 3;
    localparam int TST_BUS  = 6;

    always_comb begin
        mode = valid ? sel_to_mode(sel) : OP_OFF;
        bad  = valid && sel_is_bad(sel);
        if (mode == OP_TEST) begin
            ratio[G_CORE] = RATIO_W'(TST_CORE);
            ratio[G_USB]  = RATIO_W'(TST_USB);
            ratio[G_REF]  = RATIO_W'(TST_REF);
            ratio[G_HUB]  = RATIO_W'(TST_HUB);
            ratio[G_BUS]  = RATIO_W'(TST_BUS);
        end else begin
            ratio[G_CORE] = RATIO_W'(NORM_CORE);
            ratio[G_USB]  = RATIO_W'(NORM_USB);
            ratio[G_REF]  = RATIO_W'(NORM_REF);
            ratio[G_HUB]  = RATIO_W'(NORM_HUB);
            ratio[G_BUS]  = RATIO_W'(NORM_BUS);
        end
    end

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq #(
    parameter int SKW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       freq_sel,
    input  logic [SKW_W-1:0] skew_cyc,
    output logic             primed,
    output logic [2:0]       sel_q,
    output logic             restart,
    output logic             fast_go,
    output logic             slow_go
);

    typedef struct packed {
        logic             primed;
        logic [2:0]       sel;
        logic [SKW_W-1:0] skew;
        logic [SKW_W-1:0] wait_cnt;
        logic             restart;
        logic             fast;
        logic             slow;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    chg;

    always_comb begin
        st_d = st_q;
        chg  = !st_q.primed || (freq_sel != st_q.sel);
        if (chg) begin
            st_d.primed   = 1'b1;
            st_d.sel      = freq_sel;
            st_d.skew     = skew_cyc;
            st_d.restart  = 1'b1;
            st_d.fast     = 1'b0;
            st_d.slow     = 1'b0;
            st_d.wait_cnt = '0;
        end else if (st_q.restart) begin
            st_d.restart  = 1'b0;
            st_d.fast     = 1'b1;
            st_d.wait_cnt = st_q.skew;
            st_d.slow     = (st_q.skew == '0);
        end else if (st_q.fast && !st_q.slow) begin
            st_d.wait_cnt = st_q.wait_cnt - SKW_W'(1);
            st_d.slow     = (st_q.wait_cnt == SKW_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.restart <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign primed  = st_q.primed;
    assign sel_q   = st_q.sel;
    assign restart = st_q.restart;
    assign fast_go = st_q.fast;
    assign slow_go = st_q.slow;

    // R11: no group runs while the restart is pending
    assert_restart_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.restart |-> (!st_q.fast && !st_q.slow));

    // R7: the delayed group never starts ahead of the leading group
    assert_slow_after_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slow |-> st_q.fast);

    // R6: the leading group is released as soon as the restart clears
    assert_fast_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.restart) |-> st_q.fast);

    // R8: the latched offset only moves with a select change
    assert_skew_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && $past(st_q.primed) && $stable(st_q.sel)) |-> $stable(st_q.skew));

endmodule

// File: rtl/clkdiv_cell.sv
module clkdiv_cell #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               go,
    input  logic [RATIO_W-1:0] ratio,
    output logic               clk_o
);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic               pos;
        logic               run;
    } cell_st_t;

    cell_st_t           st_d, st_q;
    logic               neg_d, neg_q;
    logic [RATIO_W-1:0] lim, hi, nxt;
    logic               bypass;

    always_comb begin
        lim    = ratio - RATIO_W'(1);
        hi     = ratio >> 1;
        bypass = (ratio == RATIO_W'(1));
        nxt    = (st_q.cnt >= lim) ? '0 : st_q.cnt + RATIO_W'(1);
        st_d   = st_q;
        if (restart) begin
            st_d.cnt = lim;
            st_d.pos = 1'b0;
            st_d.run = 1'b0;
        end else if (go) begin
            st_d.cnt = nxt;
            st_d.pos = (nxt < hi);
            st_d.run = 1'b1;
        end
        // falling-edge copy stretches odd ratios by half a cycle
        neg_d = ratio[0] & st_q.pos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= neg_d;
    end

    assign clk_o = go & st_q.run & (bypass ? clk : (st_q.pos | neg_q));

    // R5: a running counter stays inside its period
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && go) |-> (st_q.cnt < ratio));

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int N_CORE    = 3,
    parameter int N_MEM     = 7,
    parameter int N_HUB     = 3,
    parameter int N_BUS     = 7,
    parameter int N_APIC    = 2,
    parameter int SKW_W     = 2,
    parameter int NORM_CORE = 6,
    parameter int NORM_USB  = 13,
    parameter int NORM_REF  = 42,
    parameter int NORM_HUB  = 9,
    parameter int NORM_BUS  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        freq_sel,
    input  logic [SKW_W-1:0]  skew_cyc,
    output logic [N_CORE-1:0] core_clk,
    output logic [N_MEM-1:0]  mem_clk,
    output logic [N_HUB-1:0]  hub_clk,
    output logic [N_BUS-1:0]  bus_clk,
    output logic [N_APIC-1:0] apic_clk,
    output logic              usb_clk,
    output logic              ref_clk,
    output logic              clk_oe,
    output logic              sel_bad
);

    logic            primed, restart, fast_go, slow_go;
    logic [2:0]      sel_q;
    op_mode_e        mode;
    ratio_vec_t      ratio;
    logic [NGRP-1:0] grp;

    clkdiv_seq #(.SKW_W(SKW_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq_sel (freq_sel),
        .skew_cyc (skew_cyc),
        .primed   (primed),
        .sel_q    (sel_q),
        .restart  (restart),
        .fast_go  (fast_go),
        .slow_go  (slow_go)
    );

    clkdiv_mode_dec #(
        .NORM_CORE (NORM_CORE),
        .NORM_USB  (NORM_USB),
        .NORM_REF  (NORM_REF),
        .NORM_HUB  (NORM_HUB),
        .NORM_BUS  (NORM_BUS)
    ) u_dec (
        .valid (primed),
        .sel   (sel_q),
        .mode  (mode),
        .bad   (sel_bad),
        .ratio (ratio)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_div
        clkdiv_cell #(.RATIO_W(RATIO_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .go      (SLOW_MASK[g] ? slow_go : fast_go),
            .ratio   (ratio[g]),
            .clk_o   (grp[g])
        );
    end

    always_comb begin
        clk_oe   = (mode != OP_OFF);
        core_clk = {N_CORE{grp[G_CORE] & clk_oe}};
        mem_clk  = {N_MEM{grp[G_CORE] & clk_oe}};
        usb_clk  = grp[G_USB] & clk_oe;
        ref_clk  = grp[G_REF] & clk_oe;
        hub_clk  = {N_HUB{grp[G_HUB] & clk_oe}};
        bus_clk  = {N_BUS{grp[G_BUS] & clk_oe}};
        apic_clk = {N_APIC{grp[G_BUS] & clk_oe}};
    end

    // R1: disabled pads carry no activity
    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_oe |-> (core_clk == '0 && hub_clk == '0 && bus_clk == '0 && usb_clk == 1'b0));

    // R4: the illegal flag only appears in a driving mode
    assert_bad_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_bad |-> clk_oe);

    // R7: every bus rising edge lands on a hub rising edge
    assert_hub_bus_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_clk[0]) |-> $rose(hub_clk[0]));

endmodule

// File: tb/test_clkdiv_bank.sv
module test_clkdiv_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] freq_sel = 3'b101;
    logic [1:0] skew_cyc = 2'd0;
    logic [2:0] core_clk;
    logic [6:0] mem_clk;
    logic [2:0] hub_clk;
    logic [6:0] bus_clk;
    logic [1:0] apic_clk;
    logic       usb_clk, ref_clk, clk_oe, sel_bad;

    clkdiv_bank i_clkdiv_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq_sel (freq_sel),
        .skew_cyc (skew_cyc),
        .core_clk (core_clk),
        .mem_clk  (mem_clk),
        .hub_clk  (hub_clk),
        .bus_clk  (bus_clk),
        .apic_clk (apic_clk),
        .usb_clk  (usb_clk),
        .ref_clk  (ref_clk),
        .clk_oe   (clk_oe),
        .sel_bad  (sel_bad)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // model state
    int         edge_idx = 0;
    bit         primed = 0;
    logic [2:0] seen_sel = 3'b000;
    int         lat_skew = 0, st_fast = 0, st_slow = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (edge %0d)", tag, act, exp, edge_idx);
        end
    endtask

    // group order: 0 core/mem, 1 usb, 2 ref, 3 hub, 4 bus/apic
    function automatic int rat(int g, logic [2:0] s);
        if (!s[2]) begin
            case (g) 0: return 2; 1: return 2; 2: return 1; 3: return 3; default: return 6; endcase
        end
        case (g) 0: return 6; 1: return 13; 2: return 42; 3: return 9; default: return 18; endcase
    endfunction

    function automatic bit wave(int n, int st, int k, int ph);
        int h;
        if (k < st) return 1'b0;
        h = 2 * (k - st) + ph;
        return (h % (2 * n)) < n;
    endfunction

    task automatic compare(int ph);
        bit    oe, bad;
        bit    e[5];
        string tag;
        int    k = edge_idx;
        oe  = primed && (seen_sel[2] || seen_sel[0]);
        bad = primed && seen_sel[2] && (seen_sel[1:0] != 2'b01);
        if (!primed)          tag = "R10";
        else if (!oe)         tag = "R1";
        else if (bad)         tag = "R4";
        else if (!seen_sel[2]) tag = "R2";
        else                  tag = "R3";
        for (int g = 0; g < 5; g++)
            e[g] = oe && wave(rat(g, seen_sel), (g >= 3) ? st_slow : st_fast, k, ph);
        chk({tag, " oe"}, clk_oe, oe);
        chk({tag, " R4 sel_bad"}, sel_bad, bad);
        chk({tag, " core"}, core_clk, {3{e[0]}});
        chk({tag, " mem"}, mem_clk, {7{e[0]}});
        chk({tag, " usb"}, usb_clk, e[1]);
        chk({tag, " ref"}, ref_clk, e[2]);
        chk({tag, " R7 R8 hub"}, hub_clk, {3{e[3]}});
        chk({tag, " R7 R8 bus"}, bus_clk, {7{e[4]}});
        chk({tag, " R7 R8 apic"}, apic_clk, {2{e[4]}});
        chk("R9 copies", ((&core_clk) || !(|core_clk)) && ((&mem_clk) || !(|mem_clk))
                         && (core_clk[0] == mem_clk[0]), 1);
        if (ph == 0 && oe) begin
            if (k == st_fast - 1) chk("R11 gap before start", {core_clk[0], usb_clk, hub_clk[0]}, 0);
            if (k == st_fast)     chk("R6 first fast edge", {core_clk[0], usb_clk, ref_clk}, 3'b111);
            if (lat_skew > 0 && k == st_slow - 1) chk("R7 slow still low", {hub_clk[0], bus_clk[0]}, 0);
            if (k == st_slow)     chk("R7 first slow edge", {hub_clk[0], bus_clk[0], apic_clk[0]}, 3'b111);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            edge_idx++;
            if (!rst_n) begin
                primed = 0;
            end else if (!primed || freq_sel !== seen_sel) begin
                primed   = 1;
                seen_sel = freq_sel;
                lat_skew = int'(skew_cyc);
                st_fast  = edge_idx + 2;
                st_slow  = st_fast + lat_skew;
            end
            #2 compare(0);
            @(negedge clk);
            #2 compare(1);
        end
    end

    function automatic logic pick(int which);
        case (which)
            0: return hub_clk[0];
            1: return bus_clk[0];
            2: return usb_clk;
            default: return core_clk[0];
        endcase
    endfunction

    // R5: high samples over one full period equal N
    task automatic duty(int which, int n, string tag);
        int c = 0;
        for (int i = 0; i < 2 * n; i++) begin
            @(clk);
            #2 c += int'(pick(which));
        end
        chk(tag, c, n);
    endtask

    task automatic set_sel(logic [2:0] v);
        @(negedge clk); #1 freq_sel = v;
    endtask

    task automatic set_skew(logic [1:0] v);
        @(negedge clk); #1 skew_cyc = v;
    endtask

    task automatic run(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        run(5);
        @(negedge clk); #1 rst_n = 1'b1;
        run(150);
        duty(2, 13, "R5 usb normal odd");
        duty(0, 9, "R5 hub normal odd");
        set_skew(2'd2);          // R8: no restart, offset must not move
        run(80);
        set_sel(3'b001);         // test mode, restart takes skew 2
        run(60);
        duty(0, 3, "R5 hub test odd");
        duty(1, 6, "R5 bus test");
        duty(3, 2, "R5 core test");
        set_sel(3'b000);         // off
        run(30);
        set_sel(3'b111);         // illegal
        run(120);
        set_skew(2'd3);
        set_sel(3'b101);
        run(150);
        set_skew(2'd1);
        set_sel(3'b011);         // test mode with sel[1] set
        run(60);
        set_sel(3'b110);
        run(80);
        set_sel(3'b100);
        run(80);
        set_sel(3'b010);         // off with sel[1] set
        run(20);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule